// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Block

This block is the software-visible face of a multi-channel DMA controller. It sits on a simple 32-bit word bus behind a 4 KB window, holds the global configuration and sync words, and for every channel holds source address, destination address, link pointer, control and configuration words. It keeps raw terminal-count and error status per channel and masks each with enable bits taken from that channel's own configuration word. It drives separate terminal-count, error and combined interrupt lines.

The data-movement engine is a separate block. It reads the channel words from flat output buses, writes back address, link and control words through an update port, clears channel enables when a chain ends, and raises status through one-hot set ports. The bus carries a word address, which is the byte offset shifted right by two. A read returns its data in the cycle after the request. The channel count parameter is 8 or 2, and it selects the first identification byte.

Top module: `dma_reg_bank`

## Requirements
- R1: After reset every channel word, the global configuration and sync words, all raw status bits, read data and all three interrupt outputs are zero.
- R2: Channel words sit at byte offsets 0x100 to 0x1FF. Offset bits [7:5] give the channel and bits [4:2] the word: 0 source, 1 destination, 2 link pointer, 3 control, 4 configuration. Each word reads back what was last written.
- R3: A channel number at or above the channel count, or a word select of 5 to 7, reads as 0 and a write there changes nothing.
- R4: Global byte offsets are 0x00 masked terminal-count OR masked error, 0x04 masked terminal-count, 0x0C masked error, 0x14 raw terminal-count and 0x18 raw error, with channel c in bit c.
- R5: Writing offset 0x08 clears each raw terminal-count bit where the written bit is 1, and writing 0x10 does the same for raw error bits.
- R6: When an engine set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Channel configuration bit 15 unmasks that channel's terminal-count status and bit 14 unmasks its error status. The raw status is unaffected.
- R8: Offset 0x1C reads a bitmap with bit c equal to bit 0 of channel c's configuration word.
- R9: Offsets 0xFE0 to 0xFFC read identification bytes indexed by (offset-0xFE0)>>2: 80 10 04 0A 0D F0 05 B1 for 8 channels, with a first byte of 81 for 2 channels.
- R10: The terminal-count output is the OR of masked terminal-count bits and the error output is the OR of masked error bits. The combined output is the OR of both. Each output changes one cycle after the status or mask change.
- R11: Offsets 0x20 to 0x2C and all other unmapped offsets read as 0 and ignore writes.
- R12: An engine update loads the source, destination, link and control words of its channel and overrides a bus write to those words in the same cycle. An engine enable clear forces configuration bit 0 to 0 and wins over a bus write.
- R13: Offset 0x30 holds the global configuration word and 0x34 the sync word. Both read back and drive their output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 10 | Word address (byte offset >> 2) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| eng_tc_set_i | input | NUM_CH | Terminal-count set, one bit per channel |
| eng_err_set_i | input | NUM_CH | Error set, one bit per channel |
| eng_upd_i | input | NUM_CH | Load update words into the channel |
| eng_src_i | input | 32*NUM_CH | Update source words |
| eng_dst_i | input | 32*NUM_CH | Update destination words |
| eng_lli_i | input | 32*NUM_CH | Update link pointer words |
| eng_ctrl_i | input | 32*NUM_CH | Update control words |
| eng_en_clr_i | input | NUM_CH | Clear channel enable bit |
| ch_src_o | output | 32*NUM_CH | Channel source words |
| ch_dst_o | output | 32*NUM_CH | Channel destination words |
| ch_lli_o | output | 32*NUM_CH | Channel link pointer words |
| ch_ctrl_o | output | 32*NUM_CH | Channel control words |
| ch_cfg_o | output | 32*NUM_CH | Channel configuration words |
| glb_cfg_o | output | 32 | Global configuration word |
| glb_sync_o | output | 32 | Sync word |
| irq_tc_o | output | 1 | Terminal-count interrupt |
| irq_err_o | output | 1 | Error interrupt |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong raw status bit shows on the raw status read one cycle after the next read request, and if that channel is unmasked it also shows on an interrupt line one cycle after the bad edge. A decode fault that sends a write to the wrong channel or word shows on the flat channel outputs at the next edge, and on read-back when a later read hits either location. The bench keeps a shadow of every word and status bit, checks each read and each interrupt level against it, and aims a set and a clear at the same bit in one cycle. A lost set-over-clear priority then shows as a missing raw bit.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned WAW = 10;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_GLB  = 2'd1,
    RGN_CHAN = 2'd2,
    RGN_ID   = 2'd3
  } rgn_e;

  localparam logic [2:0] CSEL_SRC  = 3'd0;
  localparam logic [2:0] CSEL_DST  = 3'd1;
  localparam logic [2:0] CSEL_LLI  = 3'd2;
  localparam logic [2:0] CSEL_CTRL = 3'd3;
  localparam logic [2:0] CSEL_CFG  = 3'd4;

  localparam logic [3:0] GI_STAT     = 4'd0;
  localparam logic [3:0] GI_TC_STAT  = 4'd1;
  localparam logic [3:0] GI_TC_CLR   = 4'd2;
  localparam logic [3:0] GI_ERR_STAT = 4'd3;
  localparam logic [3:0] GI_ERR_CLR  = 4'd4;
  localparam logic [3:0] GI_TC_RAW   = 4'd5;
  localparam logic [3:0] GI_ERR_RAW  = 4'd6;
  localparam logic [3:0] GI_EN_MAP   = 4'd7;
  localparam logic [3:0] GI_CFG      = 4'd12;
  localparam logic [3:0] GI_SYNC     = 4'd13;

  localparam int unsigned CFG_EN_BIT  = 0;
  localparam int unsigned CFG_ERR_MSK = 14;
  localparam int unsigned CFG_TC_MSK  = 15;

  function automatic logic [7:0] id_byte(input int unsigned nch, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = (nch == 2) ? 8'h81 : 8'h80;
      3'd1:    b = 8'h10;
      3'd2:    b = 8'h04;
      3'd3:    b = 8'h0A;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_reg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [WAW-1:0] addr_i,
  output rgn_e           rgn_o,
  output logic [2:0]     chan_idx_o,
  output logic [2:0]     chan_sel_o,
  output logic           chan_ok_o,
  output logic [3:0]     glb_idx_o,
  output logic [2:0]     id_idx_o
);
  always_comb begin
    chan_idx_o = addr_i[5:3];
    chan_sel_o = addr_i[2:0];
    glb_idx_o  = addr_i[3:0];
    id_idx_o   = addr_i[2:0];
    if (addr_i[9:6] == 4'h1)        rgn_o = RGN_CHAN;
    else if (addr_i[9:3] == 7'h7F)  rgn_o = RGN_ID;
    else if (addr_i[9:4] == 6'h00)  rgn_o = RGN_GLB;
    else                            rgn_o = RGN_NONE;
    chan_ok_o = (rgn_o == RGN_CHAN) && (32'(chan_idx_o) < NUM_CH) && (chan_sel_o <= CSEL_CFG);
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_reg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          upd_i,
  input  logic [DW-1:0] upd_src_i,
  input  logic [DW-1:0] upd_dst_i,
  input  logic [DW-1:0] upd_lli_i,
  input  logic [DW-1:0] upd_ctrl_i,
  input  logic          en_clr_i,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_o,
  output logic [DW-1:0] lli_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] cfg_o
);
  logic [DW-1:0] cfg_n;

  always_comb begin
    cfg_n = cfg_o;
    if (wr_i && sel_i == CSEL_CFG) cfg_n = wdata_i;
    // engine end-of-chain wins over software enable
    if (en_clr_i) cfg_n[CFG_EN_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      dst_o  <= '0;
      lli_o  <= '0;
      ctrl_o <= '0;
      cfg_o  <= '0;
    end else begin
      cfg_o <= cfg_n;
      if (upd_i) begin
        src_o  <= upd_src_i;
        dst_o  <= upd_dst_i;
        lli_o  <= upd_lli_i;
        ctrl_o <= upd_ctrl_i;
      end else if (wr_i) begin
        case (sel_i)
          CSEL_SRC:  src_o  <= wdata_i;
          CSEL_DST:  dst_o  <= wdata_i;
          CSEL_LLI:  lli_o  <= wdata_i;
          CSEL_CTRL: ctrl_o <= wdata_i;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tc_set_i,
  input  logic [NUM_CH-1:0] err_set_i,
  input  logic              tc_clr_i,
  input  logic              err_clr_i,
  input  logic [NUM_CH-1:0] clr_bits_i,
  input  logic [NUM_CH-1:0] tc_msk_i,
  input  logic [NUM_CH-1:0] err_msk_i,
  output logic [NUM_CH-1:0] raw_tc_o,
  output logic [NUM_CH-1:0] raw_err_o,
  output logic [NUM_CH-1:0] tc_stat_o,
  output logic [NUM_CH-1:0] err_stat_o,
  output logic              irq_tc_o,
  output logic              irq_err_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] tc_n, err_n;
  logic              tc_lvl, err_lvl;

  always_comb begin
    tc_n  = raw_tc_o  & ~(tc_clr_i  ? clr_bits_i : '0);
    err_n = raw_err_o & ~(err_clr_i ? clr_bits_i : '0);
    // set applied after clear: set wins
    tc_n  = tc_n  | tc_set_i;
    err_n = err_n | err_set_i;
  end

  assign tc_stat_o  = raw_tc_o  & tc_msk_i;
  assign err_stat_o = raw_err_o & err_msk_i;
  assign tc_lvl     = |tc_stat_o;
  assign err_lvl    = |err_stat_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_tc_o  <= '0;
      raw_err_o <= '0;
      irq_tc_o  <= 1'b0;
      irq_err_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      raw_tc_o  <= tc_n;
      raw_err_o <= err_n;
      irq_tc_o  <= tc_lvl;
      irq_err_o <= err_lvl;
      irq_o     <= tc_lvl | err_lvl;
    end
  end
endmodule

// File: rtl/dma_reg_bank.sv
module dma_reg_bank
  import dma_reg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [WAW-1:0]       bus_addr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  output logic [DW-1:0]        bus_rdata_o,
  input  logic [NUM_CH-1:0]    eng_tc_set_i,
  input  logic [NUM_CH-1:0]    eng_err_set_i,
  input  logic [NUM_CH-1:0]    eng_upd_i,
  input  logic [DW*NUM_CH-1:0] eng_src_i,
  input  logic [DW*NUM_CH-1:0] eng_dst_i,
  input  logic [DW*NUM_CH-1:0] eng_lli_i,
  input  logic [DW*NUM_CH-1:0] eng_ctrl_i,
  input  logic [NUM_CH-1:0]    eng_en_clr_i,
  output logic [DW*NUM_CH-1:0] ch_src_o,
  output logic [DW*NUM_CH-1:0] ch_dst_o,
  output logic [DW*NUM_CH-1:0] ch_lli_o,
  output logic [DW*NUM_CH-1:0] ch_ctrl_o,
  output logic [DW*NUM_CH-1:0] ch_cfg_o,
  output logic [DW-1:0]        glb_cfg_o,
  output logic [DW-1:0]        glb_sync_o,
  output logic                 irq_tc_o,
  output logic                 irq_err_o,
  output logic                 irq_o
);
  rgn_e        rgn;
  logic [2:0]  chan_idx, chan_sel, id_idx;
  logic [3:0]  glb_idx;
  logic        chan_ok;
  logic        bus_wr, bus_rd, chan_wr, glb_wr;
  logic [NUM_CH-1:0] tc_msk, err_msk, en_map;
  logic [NUM_CH-1:0] raw_tc, raw_err, tc_stat, err_stat;
  logic [DW-1:0]     rd_n, chan_rd;

  dma_reg_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i     (bus_addr_i),
    .rgn_o      (rgn),
    .chan_idx_o (chan_idx),
    .chan_sel_o (chan_sel),
    .chan_ok_o  (chan_ok),
    .glb_idx_o  (glb_idx),
    .id_idx_o   (id_idx)
  );

  assign bus_wr  = bus_req_i && bus_we_i;
  assign bus_rd  = bus_req_i && !bus_we_i;
  assign chan_wr = bus_wr && chan_ok;
  assign glb_wr  = bus_wr && (rgn == RGN_GLB);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_regs u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (chan_wr && (chan_idx == 3'(c))),
      .sel_i      (chan_sel),
      .wdata_i    (bus_wdata_i),
      .upd_i      (eng_upd_i[c]),
      .upd_src_i  (eng_src_i[c*DW +: DW]),
      .upd_dst_i  (eng_dst_i[c*DW +: DW]),
      .upd_lli_i  (eng_lli_i[c*DW +: DW]),
      .upd_ctrl_i (eng_ctrl_i[c*DW +: DW]),
      .en_clr_i   (eng_en_clr_i[c]),
      .src_o      (ch_src_o[c*DW +: DW]),
      .dst_o      (ch_dst_o[c*DW +: DW]),
      .lli_o      (ch_lli_o[c*DW +: DW]),
      .ctrl_o     (ch_ctrl_o[c*DW +: DW]),
      .cfg_o      (ch_cfg_o[c*DW +: DW])
    );
    assign tc_msk[c]  = ch_cfg_o[c*DW + CFG_TC_MSK];
    assign err_msk[c] = ch_cfg_o[c*DW + CFG_ERR_MSK];
    assign en_map[c]  = ch_cfg_o[c*DW + CFG_EN_BIT];
  end

  dma_irq_status #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tc_set_i   (eng_tc_set_i),
    .err_set_i  (eng_err_set_i),
    .tc_clr_i   (glb_wr && glb_idx == GI_TC_CLR),
    .err_clr_i  (glb_wr && glb_idx == GI_ERR_CLR),
    .clr_bits_i (bus_wdata_i[NUM_CH-1:0]),
    .tc_msk_i   (tc_msk),
    .err_msk_i  (err_msk),
    .raw_tc_o   (raw_tc),
    .raw_err_o  (raw_err),
    .tc_stat_o  (tc_stat),
    .err_stat_o (err_stat),
    .irq_tc_o   (irq_tc_o),
    .irq_err_o  (irq_err_o),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_cfg_o  <= '0;
      glb_sync_o <= '0;
    end else if (glb_wr) begin
      if (glb_idx == GI_CFG)  glb_cfg_o  <= bus_wdata_i;
      if (glb_idx == GI_SYNC) glb_sync_o <= bus_wdata_i;
    end
  end

  always_comb begin
    chan_rd = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chan_idx == 3'(c)) begin
        case (chan_sel)
          CSEL_SRC:  chan_rd = ch_src_o[c*DW +: DW];
          CSEL_DST:  chan_rd = ch_dst_o[c*DW +: DW];
          CSEL_LLI:  chan_rd = ch_lli_o[c*DW +: DW];
          CSEL_CTRL: chan_rd = ch_ctrl_o[c*DW +: DW];
          CSEL_CFG:  chan_rd = ch_cfg_o[c*DW +: DW];
          default:   chan_rd = '0;
        endcase
      end
    end
  end

  always_comb begin
    rd_n = '0;
    case (rgn)
      RGN_CHAN: rd_n = chan_ok ? chan_rd : '0;
      RGN_ID:   rd_n = 32'(id_byte(NUM_CH, id_idx));
      RGN_GLB: begin
        case (glb_idx)
          GI_STAT:     rd_n = 32'(tc_stat | err_stat);
          GI_TC_STAT:  rd_n = 32'(tc_stat);
          GI_ERR_STAT: rd_n = 32'(err_stat);
          GI_TC_RAW:   rd_n = 32'(raw_tc);
          GI_ERR_RAW:  rd_n = 32'(raw_err);
          GI_EN_MAP:   rd_n = 32'(en_map);
          GI_CFG:      rd_n = glb_cfg_o;
          GI_SYNC:     rd_n = glb_sync_o;
          default:     rd_n = '0;
        endcase
      end
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bus_rdata_o <= '0;
    else if (bus_rd) bus_rdata_o <= rd_n;
  end
endmodule

// File: rtl/dma_reg_bank_chk.sv
module dma_reg_bank_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_req_i,
  input logic                 bus_we_i,
  input logic [9:0]           bus_addr_i,
  input logic [NUM_CH-1:0]    clr_bits_i,
  input logic [NUM_CH-1:0]    tc_set_i,
  input logic [NUM_CH-1:0]    err_set_i,
  input logic [NUM_CH-1:0]    en_clr_i,
  input logic [NUM_CH-1:0]    raw_tc_i,
  input logic [NUM_CH-1:0]    raw_err_i,
  input logic [NUM_CH-1:0]    tc_stat_i,
  input logic [NUM_CH-1:0]    err_stat_i,
  input logic [32*NUM_CH-1:0] cfg_i,
  input logic                 irq_tc_i,
  input logic                 irq_err_i,
  input logic                 irq_i
);
  logic [NUM_CH-1:0] en_bits;
  always_comb for (int c = 0; c < NUM_CH; c++) en_bits[c] = cfg_i[c*32];

  assert_tc_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_set_i != '0) |=> ((raw_tc_i & $past(tc_set_i)) == $past(tc_set_i)));

  assert_err_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i != '0) |=> ((raw_err_i & $past(err_set_i)) == $past(err_set_i)));

  assert_tc_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == 10'd2)
      |=> ((raw_tc_i & $past(clr_bits_i & ~tc_set_i)) == '0));

  assert_err_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == 10'd4)
      |=> ((raw_err_i & $past(clr_bits_i & ~err_set_i)) == '0));

  assert_irq_tc_lag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_tc_i == $past(|tc_stat_i)));

  assert_irq_err_lag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_err_i == $past(|err_stat_i)));

  assert_irq_any_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == (irq_tc_i | irq_err_i));

  assert_en_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_clr_i != '0) |=> ((en_bits & $past(en_clr_i)) == '0));
endmodule

bind dma_reg_bank dma_reg_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .clr_bits_i (bus_wdata_i[NUM_CH-1:0]),
  .tc_set_i   (eng_tc_set_i),
  .err_set_i  (eng_err_set_i),
  .en_clr_i   (eng_en_clr_i),
  .raw_tc_i   (raw_tc),
  .raw_err_i  (raw_err),
  .tc_stat_i  (tc_stat),
  .err_stat_i (err_stat),
  .cfg_i      (ch_cfg_o),
  .irq_tc_i   (irq_tc_o),
  .irq_err_i  (irq_err_o),
  .irq_i      (irq_o)
);

// File: tb/dma_reg_bank_bench.sv
module dma_reg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         bus_req = 1'b0, bus_we = 1'b0;
  logic [9:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata, rdata2;
  logic [NCH-1:0] eng_tc = '0, eng_err = '0, eng_upd = '0, eng_enc = '0;
  logic [32*NCH-1:0] eng_src = '0, eng_dst = '0, eng_lli = '0, eng_ctrl = '0;
  logic [32*NCH-1:0] ch_src, ch_dst, ch_lli, ch_ctrl, ch_cfg;
  logic [31:0]  glb_cfg, glb_sync;
  logic         irq_tc, irq_err, irq;
  logic [63:0]  c2_src, c2_dst, c2_lli, c2_ctrl, c2_cfg;
  logic [31:0]  c2_gcfg, c2_sync;
  logic         c2_itc, c2_ierr, c2_irq;

  dma_reg_bank #(.NUM_CH(NCH)) u_dma_reg_bank (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .eng_tc_set_i(eng_tc), .eng_err_set_i(eng_err), .eng_upd_i(eng_upd),
    .eng_src_i(eng_src), .eng_dst_i(eng_dst), .eng_lli_i(eng_lli), .eng_ctrl_i(eng_ctrl),
    .eng_en_clr_i(eng_enc), .ch_src_o(ch_src), .ch_dst_o(ch_dst), .ch_lli_o(ch_lli),
    .ch_ctrl_o(ch_ctrl), .ch_cfg_o(ch_cfg), .glb_cfg_o(glb_cfg), .glb_sync_o(glb_sync),
    .irq_tc_o(irq_tc), .irq_err_o(irq_err), .irq_o(irq)
  );

  dma_reg_bank #(.NUM_CH(2)) u_dma_reg_bank_2ch (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata2),
    .eng_tc_set_i(2'b0), .eng_err_set_i(2'b0), .eng_upd_i(2'b0),
    .eng_src_i(64'b0), .eng_dst_i(64'b0), .eng_lli_i(64'b0), .eng_ctrl_i(64'b0),
    .eng_en_clr_i(2'b0), .ch_src_o(c2_src), .ch_dst_o(c2_dst), .ch_lli_o(c2_lli),
    .ch_ctrl_o(c2_ctrl), .ch_cfg_o(c2_cfg), .glb_cfg_o(c2_gcfg), .glb_sync_o(c2_sync),
    .irq_tc_o(c2_itc), .irq_err_o(c2_ierr), .irq_o(c2_irq)
  );

  int checks = 0, errors = 0;
  logic [31:0] m_src [NCH], m_dst [NCH], m_lli [NCH], m_ctrl [NCH], m_cfg [NCH];
  logic [31:0] m_gcfg, m_sync;
  logic [NCH-1:0] m_tc, m_err;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] tcm();
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = m_cfg[c][15] & m_tc[c];
    return v;
  endfunction

  function automatic logic [NCH-1:0] erm();
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = m_cfg[c][14] & m_err[c];
    return v;
  endfunction

  function automatic logic [7:0] exp_id(input int nch, input int i);
    logic [7:0] t [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (i == 0 && nch == 2) return 8'h81;
    return t[i];
  endfunction

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    int ch, sel;
    logic [NCH-1:0] en;
    if (a[9:6] == 4'h1) begin
      ch = int'(a[5:3]); sel = int'(a[2:0]);
      if (ch >= NCH) return 0;
      case (sel)
        0: return m_src[ch];
        1: return m_dst[ch];
        2: return m_lli[ch];
        3: return m_ctrl[ch];
        4: return m_cfg[ch];
        default: return 0;
      endcase
    end
    if (a[9:3] == 7'h7F) return {24'h0, exp_id(NCH, int'(a[2:0]))};
    if (a[9:4] != 0) return 0;
    for (int c = 0; c < NCH; c++) en[c] = m_cfg[c][0];
    case (a[3:0])
      4'd0:  return {24'h0, tcm() | erm()};
      4'd1:  return {24'h0, tcm()};
      4'd3:  return {24'h0, erm()};
      4'd5:  return {24'h0, m_tc};
      4'd6:  return {24'h0, m_err};
      4'd7:  return {24'h0, en};
      4'd12: return m_gcfg;
      4'd13: return m_sync;
      default: return 0;
    endcase
  endfunction

  task automatic model_apply(input logic req, input logic we, input logic [9:0] a, input logic [31:0] d);
    int ch;
    bit w;
    w = req && we;
    for (int c = 0; c < NCH; c++) begin
      ch = int'(a[5:3]);
      if (w && a[9:6] == 4'h1 && ch == c && a[2:0] == 3'd4) m_cfg[c] = d;
      if (eng_enc[c]) m_cfg[c][0] = 1'b0;
      if (eng_upd[c]) begin
        m_src[c] = eng_src[c*32 +: 32]; m_dst[c] = eng_dst[c*32 +: 32];
        m_lli[c] = eng_lli[c*32 +: 32]; m_ctrl[c] = eng_ctrl[c*32 +: 32];
      end else if (w && a[9:6] == 4'h1 && ch == c) begin
        case (a[2:0])
          3'd0: m_src[c] = d;
          3'd1: m_dst[c] = d;
          3'd2: m_lli[c] = d;
          3'd3: m_ctrl[c] = d;
          default: ;
        endcase
      end
    end
    if (w && a[9:4] == 0) begin
      if (a[3:0] == 4'd2)  m_tc  = m_tc  & ~d[NCH-1:0];
      if (a[3:0] == 4'd4)  m_err = m_err & ~d[NCH-1:0];
      if (a[3:0] == 4'd12) m_gcfg = d;
      if (a[3:0] == 4'd13) m_sync = d;
    end
    m_tc  = m_tc  | eng_tc;
    m_err = m_err | eng_err;
  endtask

  task automatic bus_op(input logic req, input logic we, input logic [9:0] a,
                        input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    bus_req = req; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    rd = bus_rdata;
    model_apply(req, we, a, d);
    bus_req = 1'b0; bus_we = 1'b0;
    eng_tc = '0; eng_err = '0; eng_upd = '0; eng_enc = '0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] rd;
    bus_op(1'b1, 1'b1, a, d, rd);
  endtask

  task automatic idle();
    logic [31:0] rd;
    bus_op(1'b0, 1'b0, 10'd0, 32'd0, rd);
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a);
    logic [31:0] rd, exp;
    exp = exp_read(a);
    bus_op(1'b1, 1'b0, a, 32'd0, rd);
    chk(req, rd, exp);
    chk({req, " irq_tc"}, {31'd0, irq_tc}, {31'd0, |tcm()});
    chk({req, " irq_err"}, {31'd0, irq_err}, {31'd0, |erm()});
    chk({req, " irq"}, {31'd0, irq}, {31'd0, (|tcm()) | (|erm())});
  endtask

  function automatic logic [9:0] ch_addr(input int ch, input int sel);
    return {4'h1, 3'(ch), 3'(sel)};
  endfunction

  function automatic logic [9:0] rand_addr();
    case ($urandom % 6)
      0, 1: return ch_addr($urandom % 8, $urandom % 8);
      2:    return {6'h0, 4'($urandom)};
      3:    return {7'h7F, 3'($urandom)};
      4:    return ch_addr($urandom % 8, 4);
      default: return 10'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin
      m_src[c] = 0; m_dst[c] = 0; m_lli[c] = 0; m_ctrl[c] = 0; m_cfg[c] = 0;
    end
    m_gcfg = 0; m_sync = 0; m_tc = 0; m_err = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 irq", {29'd0, irq, irq_tc, irq_err}, 0);
    chk("R1 cfg out", ch_cfg[31:0], 0);
    rst_n = 1'b1;
    rd_chk("R1 raw tc", 10'd5);
    rd_chk("R1 ch7 ctrl", ch_addr(7, 3));
    rd_chk("R1 glb cfg", 10'd12);

    // R2 channel read-back
    wr(ch_addr(3, 0), 32'hA000_1000);
    wr(ch_addr(3, 1), 32'hB000_2000);
    wr(ch_addr(3, 2), 32'hC000_3000);
    wr(ch_addr(3, 3), 32'h0000_0123);
    chk("R2 src port", ch_src[3*32 +: 32], 32'hA000_1000);
    rd_chk("R2 src", ch_addr(3, 0));
    rd_chk("R2 dst", ch_addr(3, 1));
    rd_chk("R2 lli", ch_addr(3, 2));
    rd_chk("R2 ctrl", ch_addr(3, 3));

    // R3 bad select and bad channel
    wr(ch_addr(3, 5), 32'hFFFF_FFFF);
    rd_chk("R3 sel5", ch_addr(3, 5));
    rd_chk("R3 neighbour intact", ch_addr(3, 3));
    wr(ch_addr(2, 0), 32'h1234_5678);
    bus_op(1'b1, 1'b0, ch_addr(2, 0), 0, rd);
    chk("R3 2ch bad channel", rdata2, 0);
    chk("R3 2ch ch0 untouched", c2_src[31:0], 0);

    // R9 ID bytes
    for (int i = 0; i < 8; i++) begin
      rd_chk("R9 id", {7'h7F, 3'(i)});
      chk("R9 id 2ch", rdata2, {24'h0, exp_id(2, i)});
    end

    // R7 masking, R10 timing
    eng_tc = 8'h02; idle();
    rd_chk("R7 raw shows unmasked", 10'd5);
    rd_chk("R7 masked hidden", 10'd1);
    wr(ch_addr(1, 4), 32'h0000_8000);
    chk("R10 lag after mask", {31'd0, irq_tc}, 0);
    @(negedge clk);
    chk("R10 tc one cycle later", {31'd0, irq_tc}, 1);
    chk("R10 combined", {31'd0, irq}, 1);
    rd_chk("R4 masked combined", 10'd0);
    eng_err = 8'h02; wr(ch_addr(1, 4), 32'h0000_C000);
    rd_chk("R4 masked err", 10'd3);
    rd_chk("R4 raw err", 10'd6);

    // R5 W1C and R6 set wins
    wr(10'd2, 32'h0000_0002);
    rd_chk("R5 tc cleared", 10'd5);
    wr(10'd4, 32'h0000_00FF);
    rd_chk("R5 err cleared", 10'd6);
    eng_tc = 8'h04; eng_err = 8'h04;
    wr(10'd2, 32'h0000_00FF);
    rd_chk("R6 tc set wins", 10'd5);
    eng_err = 8'h08;
    wr(10'd4, 32'h0000_0008);
    rd_chk("R6 err set wins", 10'd6);

    // R8 enabled map, R12 enable clear and update priority
    wr(ch_addr(5, 4), 32'h1);
    wr(ch_addr(6, 4), 32'h1);
    rd_chk("R8 enable map", 10'd7);
    eng_enc = 8'h20; wr(ch_addr(5, 4), 32'h1);
    rd_chk("R12 enable clear wins", 10'd7);
    eng_upd = 8'h10; eng_src[4*32 +: 32] = 32'hDEAD_0004; eng_ctrl[4*32 +: 32] = 32'h0000_0077;
    wr(ch_addr(4, 0), 32'h5555_5555);
    rd_chk("R12 update wins src", ch_addr(4, 0));
    rd_chk("R12 update ctrl", ch_addr(4, 3));
    eng_src = '0; eng_ctrl = '0;

    // R11 soft request and unmapped
    for (int i = 8; i < 12; i++) begin
      wr(10'(i), 32'hFFFF_FFFF);
      rd_chk("R11 soft req", 10'(i));
    end
    wr(10'h020, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped", 10'h020);

    // R13 global words
    wr(10'd12, 32'h0000_0001);
    wr(10'd13, 32'h0000_ABCD);
    rd_chk("R13 cfg", 10'd12);
    rd_chk("R13 sync", 10'd13);
    chk("R13 cfg port", glb_cfg, 32'h1);
    chk("R13 sync port", glb_sync, 32'hABCD);

    // random mix (R2..R12)
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 3 == 0) begin
        if ($urandom % 3 == 0) eng_tc  = NCH'($urandom);
        if ($urandom % 3 == 0) eng_err = NCH'($urandom);
        if ($urandom % 6 == 0) eng_enc = NCH'($urandom);
        if ($urandom % 6 == 0) begin
          eng_upd = NCH'($urandom);
          for (int c = 0; c < NCH; c++) begin
            eng_src[c*32 +: 32] = $urandom; eng_dst[c*32 +: 32] = $urandom;
            eng_lli[c*32 +: 32] = $urandom; eng_ctrl[c*32 +: 32] = $urandom;
          end
        end
        wr(rand_addr(), $urandom);
      end else begin
        rd_chk("R4 random read", rand_addr());
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule